// File: doc/BRIEF.md
# Packet-Mode I2C Command Parser

This block turns a stream of 32-bit words from a transmit FIFO into work for a byte-level I2C bit engine. Every transfer arrives in-band as three header words followed, for writes only, by payload words. The parser reads the headers in order (first the identifier word, then the length word, then the target word) and presents one transfer descriptor to the engine: packet identifier, 7-bit target address, direction, byte count, and whether the transfer closes with a repeated start instead of a stop. For a write it then splits each payload word into bytes, lowest byte first, and hands them out one at a time. Only the bytes the count calls for are sent.

The engine reports completion, a missing acknowledge or lost arbitration with single-cycle pulses. Each pulse sets its own sticky status flag, and software clears a flag by writing a one to its bit. If a transfer is aborted by a missing acknowledge or lost arbitration, the parser drops the rest of that packet's payload words from the FIFO and waits for the next header. All interfaces are valid/ready.

The controller is a state machine with these states:
- `ST_HDR_A`: waits for the identifier word.
- `ST_HDR_B`: takes the length word.
- `ST_HDR_C`: takes the target word.
- `ST_ISSUE`: offers the descriptor. When it is accepted the machine goes to `ST_WAIT` for a read or `ST_LOAD` for a write.
- `ST_LOAD`: pulls one payload word, then goes to `ST_EMIT`.
- `ST_EMIT`: hands out bytes. After the last byte it goes to `ST_WAIT`. After the top byte lane it goes back to `ST_LOAD`.
- `ST_WAIT`: waits for the completion pulse, then returns to `ST_HDR_A`.

An abort in `ST_LOAD`, `ST_EMIT` or `ST_WAIT` leads to `ST_FLUSH` if payload words are still left in the FIFO, and to `ST_HDR_A` otherwise. `ST_FLUSH` drops words until none are left, then returns to `ST_HDR_A`.

Top module: `i2c_pkt_parser`

## Requirements
- R1: After reset, the first FIFO word is taken as the identifier header, the next as the length header and the next as the target header. The packet identifier is bits [7:0] of the identifier word, and all other bits of that word are ignored.
- R2: The byte count on `cmd_len` equals bits [11:0] of the length word plus one, so counts run from 1 to 4096.
- R3: The target word carries an 8-bit address field in bits [7:0]. `cmd_addr` is bits [7:1] of that field, and bit 0 has no effect. Bit 19 set means a read and clear means a write.
- R4: Bit 16 of the target word appears on `cmd_rstart` (1 = end with a repeated start).
- R5: For a write of N bytes, exactly ceil(N/4) payload words are taken from the FIFO. Bytes go out lowest byte lane first ([7:0] first, [31:24] last), and exactly N bytes are sent, so unused lanes of the last word are dropped.
- R6: A read takes no payload words. The FIFO word after its target header is the next transfer's identifier header.
- R7: `sts_flags` bit 0 (complete), bit 1 (missing acknowledge) and bit 2 (lost arbitration) are each set one cycle after the matching engine pulse and stay set.
- R8: When `sts_clr_we` is high, each flag whose `sts_clr_mask` bit is one is cleared on the next edge. If a set and a clear hit the same flag in the same cycle, the set wins.
- R9: A missing-acknowledge or lost-arbitration pulse during a transfer stops byte output. The parser drops that packet's remaining payload words and decodes the following word as a new identifier header.
- R10: While `cmd_valid` or `wr_valid` is high without the matching ready, the offered descriptor or byte stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_data | input | 32 | Word from the transmit FIFO |
| fifo_valid | input | 1 | FIFO word present |
| fifo_ready | output | 1 | Parser takes the word this cycle |
| cmd_valid | output | 1 | Descriptor offered to the engine |
| cmd_ready | input | 1 | Engine accepts the descriptor |
| cmd_pkt_id | output | 8 | Packet identifier |
| cmd_addr | output | 7 | 7-bit target address |
| cmd_read | output | 1 | 1 = read, 0 = write |
| cmd_len | output | 13 | Byte count (1..4096) |
| cmd_rstart | output | 1 | End with a repeated start instead of a stop |
| wr_data | output | 8 | Write byte to the engine |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | Engine takes the byte |
| eng_done | input | 1 | Transfer complete pulse |
| eng_nack | input | 1 | Missing acknowledge pulse |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| sts_clr_we | input | 1 | Write strobe for clearing status flags |
| sts_clr_mask | input | 3 | Ones clear the matching flags |
| sts_flags | output | 3 | Sticky status flags {arbitration, no-ack, complete} |

## Verification
Writes are tried with byte counts of 1, 4, 5, 11 and 64, so that exact word multiples, a single byte and partly filled final words are all covered. Together these tell apart errors in rounding the word count and leaks of unused byte lanes. Reads of 7 and 4096 bytes, placed between writes, show whether the parser wrongly takes payload words for a read and whether the largest length field decodes. Aborts are injected after zero bytes, mid-word, and during a read. In each case a clean transfer follows, which exposes a flush that drops one word too many or too few. Engine back-pressure on the descriptor and byte channels checks that offers are held, and a status clear that collides with a set shows which of the two wins.

// File: rtl/i2c_pkt_pkg.sv
package i2c_pkt_pkg;

    typedef enum logic [2:0] {
        ST_HDR_A,
        ST_HDR_B,
        ST_HDR_C,
        ST_ISSUE,
        ST_LOAD,
        ST_EMIT,
        ST_WAIT,
        ST_FLUSH
    } pkt_state_e;

    // header field positions (decoded by the engine-facing descriptor)
    localparam int PID_LSB  = 0;
    localparam int PID_W    = 8;
    localparam int LEN_LSB  = 0;
    localparam int ADDR_LSB = 0;
    localparam int ADDR_W   = 7;
    localparam int RS_BIT   = 16;
    localparam int RD_BIT   = 19;

    // status flag indices
    localparam int FLG_DONE = 0;
    localparam int FLG_NACK = 1;
    localparam int FLG_ARB  = 2;
    localparam int NFLAG    = 3;

endpackage

// File: rtl/i2c_pkt_hdr_dec.sv
module i2c_pkt_hdr_dec
    import i2c_pkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic [WORD_W-1:0] word,
    output logic [PID_W-1:0]  pid,
    output logic [LEN_W-1:0]  len_m1,
    output logic [ADDR_W-1:0] addr7,
    output logic              rd,
    output logic              rs
);
    // identifier word: only the packet id is kept
    assign pid    = word[PID_LSB +: PID_W];
    // length word: byte count minus one
    assign len_m1 = word[LEN_LSB +: LEN_W];
    // target word: address field bit 0 is dropped, direction taken from rd bit
    assign addr7  = word[ADDR_LSB+1 +: ADDR_W];
    assign rd     = word[RD_BIT];
    assign rs     = word[RS_BIT];
endmodule

// File: rtl/i2c_pkt_byte_sel.sv
module i2c_pkt_byte_sel #(
    parameter int WORD_W = 32,
    parameter int BYTES  = WORD_W / 8,
    parameter int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        byte_o
);
    logic [7:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = word[g*8 +: 8];
    end

    assign byte_o = lane[idx];
endmodule

// File: rtl/i2c_pkt_status.sv
module i2c_pkt_status #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_mask,
    output logic [NF-1:0] flags
);
    for (genvar g = 0; g < NF; g++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_i[g])
                flag_q <= 1'b1;
            else if (clr_we && clr_mask[g])
                flag_q <= 1'b0;
        end

        assign flags[g] = flag_q;

        a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags[g]);

        a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[g] && !set_i[g]) |=> !flags[g]);

        a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !(clr_we && clr_mask[g])) |=> flags[g]);
    end
endmodule

// File: rtl/i2c_pkt_ctl.sv
module i2c_pkt_ctl
    import i2c_pkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12,
    parameter int BYTES  = WORD_W / 8,
    parameter int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
    parameter int CNT_W  = LEN_W + 1,
    parameter int WL_W   = LEN_W - IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_valid,
    output logic              fifo_ready,
    input  logic [PID_W-1:0]  dec_pid,
    input  logic [LEN_W-1:0]  dec_len_m1,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_rd,
    input  logic              dec_rs,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [PID_W-1:0]  cmd_pkt_id,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_read,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              cmd_rstart,
    output logic [WORD_W-1:0] word_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic              done_i,
    input  logic              abort_i
);
    pkt_state_e state_q, state_d;

    logic [PID_W-1:0]  pid_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic              rs_q;
    logic [CNT_W-1:0]  len_q;
    logic [CNT_W-1:0]  left_q;
    logic [WL_W-1:0]   words_q;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              take;

    assign take = fifo_valid && fifo_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HDR_A;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR_A: if (fifo_valid) state_d = ST_HDR_B;
            ST_HDR_B: if (fifo_valid) state_d = ST_HDR_C;
            ST_HDR_C: if (fifo_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready)  state_d = rd_q ? ST_WAIT : ST_LOAD;
            ST_LOAD: begin
                if (abort_i)
                    state_d = (words_q > WL_W'(fifo_valid)) ? ST_FLUSH : ST_HDR_A;
                else if (fifo_valid)
                    state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (abort_i)
                    state_d = (words_q != '0) ? ST_FLUSH : ST_HDR_A;
                else if (wr_ready) begin
                    if (left_q == CNT_W'(1))
                        state_d = ST_WAIT;
                    else if (idx_q == IDX_W'(BYTES-1))
                        state_d = ST_LOAD;
                end
            end
            ST_WAIT:  if (done_i || abort_i) state_d = ST_HDR_A;
            ST_FLUSH: if (fifo_valid && words_q == WL_W'(1)) state_d = ST_HDR_A;
            default:  state_d = ST_HDR_A;
        endcase
    end

    // outputs
    always_comb begin
        fifo_ready = 1'b0;
        cmd_valid  = 1'b0;
        wr_valid   = 1'b0;
        unique case (state_q)
            ST_HDR_A, ST_HDR_B, ST_HDR_C, ST_LOAD, ST_FLUSH: fifo_ready = 1'b1;
            ST_ISSUE: cmd_valid = 1'b1;
            ST_EMIT:  wr_valid  = 1'b1;
            default: ;
        endcase
    end

    // descriptor and payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q   <= '0;
            addr_q  <= '0;
            rd_q    <= 1'b0;
            rs_q    <= 1'b0;
            len_q   <= '0;
            left_q  <= '0;
            words_q <= '0;
            word_q  <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_HDR_A: if (take) pid_q <= dec_pid;
                ST_HDR_B: if (take) begin
                    len_q   <= CNT_W'(dec_len_m1) + CNT_W'(1);
                    left_q  <= CNT_W'(dec_len_m1) + CNT_W'(1);
                    words_q <= WL_W'(dec_len_m1 >> IDX_W) + WL_W'(1);
                end
                ST_HDR_C: if (take) begin
                    addr_q <= dec_addr;
                    rd_q   <= dec_rd;
                    rs_q   <= dec_rs;
                end
                ST_LOAD: if (take) begin
                    word_q  <= fifo_data;
                    idx_q   <= '0;
                    words_q <= words_q - WL_W'(1);
                end
                ST_EMIT: if (wr_ready && !abort_i) begin
                    idx_q  <= idx_q + IDX_W'(1);
                    left_q <= left_q - CNT_W'(1);
                end
                ST_FLUSH: if (take) words_q <= words_q - WL_W'(1);
                default: ;
            endcase
        end
    end

    assign cmd_pkt_id = pid_q;
    assign cmd_addr   = addr_q;
    assign cmd_read   = rd_q;
    assign cmd_len    = len_q;
    assign cmd_rstart = rs_q;
    assign word_o     = word_q;
    assign idx_o      = idx_q;

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid &&
            $stable({cmd_pkt_id, cmd_addr, cmd_read, cmd_len, cmd_rstart})));

    a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && (state_q == ST_EMIT || state_q == ST_LOAD)) |=> !wr_valid);

    a_r5_byte_budget: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (left_q != '0 && !rd_q));

    a_r6_read_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_read) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/i2c_pkt_parser.sv
module i2c_pkt_parser
    import i2c_pkt_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12,
    localparam int BYTES = WORD_W / 8,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_valid,
    output logic              fifo_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_pkt_id,
    output logic [6:0]        cmd_addr,
    output logic              cmd_read,
    output logic [CNT_W-1:0]  cmd_len,
    output logic              cmd_rstart,
    output logic [7:0]        wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_arb_lost,
    input  logic              sts_clr_we,
    input  logic [2:0]        sts_clr_mask,
    output logic [2:0]        sts_flags
);
    logic [PID_W-1:0]  dec_pid;
    logic [LEN_W-1:0]  dec_len_m1;
    logic [ADDR_W-1:0] dec_addr;
    logic              dec_rd;
    logic              dec_rs;
    logic [WORD_W-1:0] word_w;
    logic [IDX_W-1:0]  idx_w;
    logic              abort_w;
    logic [NFLAG-1:0]  set_w;

    assign abort_w = eng_nack | eng_arb_lost;

    always_comb begin
        set_w           = '0;
        set_w[FLG_DONE] = eng_done;
        set_w[FLG_NACK] = eng_nack;
        set_w[FLG_ARB]  = eng_arb_lost;
    end

    i2c_pkt_hdr_dec #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dec (
        .word   (fifo_data),
        .pid    (dec_pid),
        .len_m1 (dec_len_m1),
        .addr7  (dec_addr),
        .rd     (dec_rd),
        .rs     (dec_rs)
    );

    i2c_pkt_ctl #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_data  (fifo_data),
        .fifo_valid (fifo_valid),
        .fifo_ready (fifo_ready),
        .dec_pid    (dec_pid),
        .dec_len_m1 (dec_len_m1),
        .dec_addr   (dec_addr),
        .dec_rd     (dec_rd),
        .dec_rs     (dec_rs),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_pkt_id (cmd_pkt_id),
        .cmd_addr   (cmd_addr),
        .cmd_read   (cmd_read),
        .cmd_len    (cmd_len),
        .cmd_rstart (cmd_rstart),
        .word_o     (word_w),
        .idx_o      (idx_w),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .done_i     (eng_done),
        .abort_i    (abort_w)
    );

    i2c_pkt_byte_sel #(.WORD_W(WORD_W)) u_sel (
        .word   (word_w),
        .idx    (idx_w),
        .byte_o (wr_data)
    );

    i2c_pkt_status #(.NF(NFLAG)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .clr_we   (sts_clr_we),
        .clr_mask (sts_clr_mask),
        .flags    (sts_flags)
    );

    a_r10_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !abort_w) |=> (wr_valid && $stable(wr_data)));

    a_r1_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_ready, cmd_valid, wr_valid}));
endmodule

// File: tb/i2c_pkt_parser_test.sv
`timescale 1ns/1ps
module i2c_pkt_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_valid = 1'b0;
    logic        fifo_ready;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [7:0]  cmd_pkt_id;
    logic [6:0]  cmd_addr;
    logic        cmd_read;
    logic [12:0] cmd_len;
    logic        cmd_rstart;
    logic [7:0]  wr_data;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_nack = 1'b0;
    logic        eng_arb_lost = 1'b0;
    logic        sts_clr_we = 1'b0;
    logic [2:0]  sts_clr_mask = '0;
    logic [2:0]  sts_flags;

    always #10 clk = ~clk;

    i2c_pkt_parser uut (
        .clk(clk), .rst_n(rst_n),
        .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_pkt_id(cmd_pkt_id),
        .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_len(cmd_len),
        .cmd_rstart(cmd_rstart), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost), .sts_clr_we(sts_clr_we),
        .sts_clr_mask(sts_clr_mask), .sts_flags(sts_flags)
    );

    // reference model state
    logic [31:0] fq[$];
    int          e_pid[$];
    int          e_addr[$];
    int          e_rd[$];
    int          e_rs[$];
    int          e_len[$];
    logic [7:0]  eb[$];
    logic [2:0]  exp_sts = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          cmd_seen = 0;
    int          byte_seen = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock of stimulus plus comparison against the model
    task automatic step(input bit dn, input bit nk, input bit ar, input bit wrr,
                        input bit cmr, input bit cw, input logic [2:0] cm);
        @(negedge clk);
        cyc++;
        chk(sts_flags == exp_sts, "R7/R8 status flags", 32'(sts_flags), 32'(exp_sts));
        fifo_valid   = (fq.size() > 0);
        fifo_data    = (fq.size() > 0) ? fq[0] : 32'h0;
        eng_done     = dn;
        eng_nack     = nk;
        eng_arb_lost = ar;
        wr_ready     = wrr;
        cmd_ready    = cmr;
        sts_clr_we   = cw;
        sts_clr_mask = cm;
        #1;
        if (fifo_valid && fifo_ready) void'(fq.pop_front());
        if (cmd_valid && cmd_ready) begin
            cmd_seen++;
            if (e_pid.size() == 0) begin
                chk(1'b0, "R1 unexpected descriptor", 32'(cmd_len), 32'h0);
            end else begin
                chk(cmd_pkt_id == 8'(e_pid[0]), "R1 packet id", 32'(cmd_pkt_id), 32'(e_pid[0]));
                chk(cmd_len == 13'(e_len[0]), "R2 byte count", 32'(cmd_len), 32'(e_len[0]));
                chk(cmd_addr == 7'(e_addr[0]), "R3 address", 32'(cmd_addr), 32'(e_addr[0]));
                chk(cmd_read == 1'(e_rd[0]), "R3 direction", 32'(cmd_read), 32'(e_rd[0]));
                chk(cmd_rstart == 1'(e_rs[0]), "R4 repeated start", 32'(cmd_rstart), 32'(e_rs[0]));
                void'(e_pid.pop_front()); void'(e_len.pop_front());
                void'(e_addr.pop_front()); void'(e_rd.pop_front());
                void'(e_rs.pop_front());
            end
        end
        if (wr_valid && wr_ready) begin
            byte_seen++;
            if (eb.size() == 0)
                chk(1'b0, "R5 unexpected byte", 32'(wr_data), 32'h0);
            else
                chk(wr_data == eb.pop_front(), "R5 byte order", 32'(wr_data), 32'h0);
        end
        exp_sts = (exp_sts & ~(cw ? cm : 3'b000)) | {ar, nk, dn};
    endtask

    task automatic idle(input int n);
        repeat (n) step(0, 0, 0, 0, 0, 0, 3'b000);
    endtask

    // kind: 0 clean, 1 missing ack, 2 lost arbitration
    task automatic xfer(input int pid, input int a7, input bit lsb, input bit rd,
                        input bit rs, input int cnt, input int kind, input int at);
        int c0 = cmd_seen;
        int b0 = byte_seen;
        int guard = 0;
        bit over = 0;
        logic [7:0] bytes[$];
        for (int i = 0; i < cnt; i++) bytes.push_back(8'((pid * 7 + i * 13 + cnt) & 255));
        fq.push_back(32'h5A3C_0000 | 32'(pid & 255));
        fq.push_back(32'hFFFF_0000 | 32'((cnt - 1) & 12'hFFF));
        fq.push_back((32'(rd) << 19) | (32'(rs) << 16) | 32'({7'(a7), lsb}) | 32'hA0E0_0000);
        if (!rd) begin
            for (int w = 0; w < (cnt + 3) / 4; w++) begin
                logic [31:0] wd = '0;
                for (int l = 0; l < 4; l++)
                    if (w * 4 + l < cnt) wd[l*8 +: 8] = bytes[w*4 + l];
                    else wd[l*8 +: 8] = 8'hEE;
                fq.push_back(wd);
            end
            foreach (bytes[i]) eb.push_back(bytes[i]);
        end
        e_pid.push_back(pid & 255); e_addr.push_back(a7); e_rd.push_back(rd);
        e_rs.push_back(rs); e_len.push_back(cnt);
        while (!over && guard < 20000) begin
            bit got;
            int bd;
            guard++;
            got = (cmd_seen > c0);
            bd  = byte_seen - b0;
            if (kind != 0 && got && bd == at) begin
                step(0, kind == 1, kind == 2, 0, 0, 0, 3'b000);
                eb.delete();
                over = 1;
            end else if (kind == 0 && got && (rd || bd == cnt)) begin
                step(0, 0, 0, 0, 0, 0, 3'b000);
                step(1, 0, 0, 0, 0, 0, 3'b000);
                over = 1;
            end else begin
                step(0, 0, 0, (cyc % 3) != 2, (cyc % 4) != 1, 0, 3'b000);
            end
        end
        idle(cnt / 4 + 6);
        chk(fq.size() == 0, rd ? "R6 words consumed" : (kind != 0 ? "R9 flush drained" : "R5 words consumed"),
            32'(fq.size()), 32'h0);
        chk(eb.size() == 0, "R5 all bytes sent", 32'(eb.size()), 32'h0);
        chk(e_pid.size() == 0, "R1 descriptor issued", 32'(e_pid.size()), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state: waiting for a header
        chk(fifo_ready == 1'b1, "R1 reset fifo_ready", 32'(fifo_ready), 32'h1);
        chk(cmd_valid == 1'b0, "R1 reset cmd_valid", 32'(cmd_valid), 32'h0);
        chk(wr_valid == 1'b0, "R1 reset wr_valid", 32'(wr_valid), 32'h0);
        chk(sts_flags == 3'b000, "R7 reset flags", 32'(sts_flags), 32'h0);

        xfer(8'h11, 7'h50, 0, 0, 0, 1, 0, 0);      // single byte
        xfer(8'h22, 7'h2A, 0, 0, 0, 4, 0, 0);      // exact word
        xfer(8'h33, 7'h13, 1, 0, 1, 5, 0, 0);      // R3 lsb ignored, R4 rstart
        xfer(8'h44, 7'h7F, 0, 0, 0, 11, 0, 0);     // partial final word
        xfer(8'h55, 7'h08, 1, 1, 1, 7, 0, 0);      // R6 read
        xfer(8'h66, 7'h01, 0, 1, 0, 4096, 0, 0);   // R2 max count
        xfer(8'h77, 7'h3C, 0, 0, 0, 64, 0, 0);
        // R8 clear with no set
        step(0, 0, 0, 0, 0, 1, 3'b001);
        idle(2);
        xfer(8'h88, 7'h45, 0, 0, 0, 13, 1, 2);     // R9 nack mid word
        xfer(8'h99, 7'h21, 0, 0, 1, 9, 2, 0);      // R9 arb before any byte
        xfer(8'hAA, 7'h66, 0, 1, 0, 3, 1, 0);      // R9 nack on read
        xfer(8'hBB, 7'h5D, 1, 0, 0, 6, 0, 0);      // clean after aborts
        // R8 set wins over a clear in the same cycle
        step(1, 0, 0, 0, 0, 1, 3'b111);
        idle(1);
        step(0, 0, 0, 0, 0, 1, 3'b110);
        idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule